// File: doc/BRIEF.md
# Background Tile Fetch Sequencer

This block produces the background memory access pattern of a tile-based raster video generator for each line that is being drawn. Each cycle it receives the current dot number (0 to 340), the current line number and a rendering-enable bit. From these it produces five things: a fetch type, an address-latch-enable strobe, an active-low read strobe, a fetch-valid flag, and four single-dot pulses. The pulses tell the scroll address register when to step horizontally, step vertically, reload its horizontal bits and reload its vertical bits. The block does no address arithmetic itself. It only decides which kind of access happens on each dot and when the scroll register must act.

Every access takes two dots. On the first dot the address is driven and the latch strobe is high. On the second dot the read strobe is low. The accesses are shifted one dot late, so dot 0 only carries a latch-strobe pulse. At the end of each line there are two nametable reads whose data is thrown away. On some frames the line counter skips the last dot of the pre-render line. In that case the following dot 0 takes over the read half of the second throwaway fetch, so that fetch still completes.

A phase state machine tracks the dot type. Its states are:

- ST_OFF: not a rendering line, or rendering is disabled.
- ST_LEAD: the dot-0 latch pulse.
- ST_ADDR: the address dot of a fetch.
- ST_READ: the read dot of a fetch.
- ST_GAP: a rendering dot with no background fetch.

Its transitions are:

- Any state moves to ST_OFF when the line is not a rendering line or rendering is off.
- Dot 0 moves to ST_LEAD, or to ST_READ if the previous state was ST_ADDR (the dropped-dot completion).
- An odd fetch dot moves to ST_ADDR.
- An even fetch dot moves to ST_READ.
- Any other rendering dot moves to ST_GAP.

All outputs are registered. The dot and line presented before a rising clock edge are reflected on the outputs after that edge. The one exception is `ale_o`, which is the registered latch phase ANDed with the clock high phase.

Top module: `bg_fetch_seq`

## Requirements
- R1: While reset is asserted, the outputs are quiet: `fetch_active_o`=0, `ale_o`=0, `rd_n_o`=1, `fetch_kind_o`=0, and all four pulses are 0.
- R2: On dot 0 of a rendering line, when the previous dot was not an address dot, `ale_o` pulses high and there is no read: `rd_n_o`=1 and `fetch_active_o`=0.
- R3: On dots 1–256 and 321–336 of a rendering line, an odd dot is an address dot and an even dot is a read dot. In both cases `fetch_active_o`=1 and `fetch_kind_o` = ((dot−1)/2) mod 4, encoded as 0 nametable, 1 attribute, 2 pattern low, 3 pattern high. A full line therefore gives 36 nametable reads and 34 reads of each other kind.
- R4: On an address dot, `ale_o` is high while the clock is high (the first half of the dot) and low while it is low, and `rd_n_o`=1.
- R5: On a read dot, `rd_n_o` is 0 for the whole dot and `ale_o` is 0.
- R6: Dots 337–338 and 339–340 are two nametable fetches (kind 0).
- R7: `hinc_o` pulses on each dot that is a multiple of 8 from 8 through 256, and on dots 328 and 336.
- R8: `vinc_o` pulses only on dot 256, together with `hinc_o`. `hload_o` pulses only on dot 257.
- R9: `vload_o` is high on every dot from 280 through 304 of the pre-render line (line 261), and never on visible lines.
- R10: Dots 257–320 carry no background fetch: `fetch_active_o`=0 and `rd_n_o`=1.
- R11: With rendering disabled, or on lines 240–260, there are no fetches, no strobes and no pulses.
- R12: If dot 0 directly follows an address dot (line 261 ended at dot 339), dot 0 is the read half of that nametable fetch: `rd_n_o`=0, `fetch_kind_o`=0 and no `ale_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_i | input | 9 | Current dot number, 0 to 340 |
| line_i | input | 9 | Current line number, 0 to 261 |
| render_en_i | input | 1 | Background rendering enabled |
| fetch_active_o | output | 1 | A background fetch occupies this dot |
| fetch_kind_o | output | 2 | 0 nametable, 1 attribute, 2 pattern low, 3 pattern high |
| ale_o | output | 1 | Address latch enable, high in first half of address dots and dot 0 |
| rd_n_o | output | 1 | Active-low read strobe |
| hinc_o | output | 1 | Horizontal scroll increment pulse |
| vinc_o | output | 1 | Vertical scroll increment pulse |
| hload_o | output | 1 | Horizontal scroll reload pulse |
| vload_o | output | 1 | Vertical scroll reload pulse |

## Verification
Some behaviours are checked by assertions on every cycle:

- a read dot is always directly preceded by an address dot, which also covers the dropped-dot completion;
- the pulses and strobes stay silent in the cycle after rendering is disabled;
- the vertical step always coincides with a horizontal step;
- the horizontal reload never lands on a fetch dot.

The exact dot numbers are shown only by the bench scenarios:

- the fetch-type rotation;
- the throwaway nametable pair;
- the pre-render vertical reload window;
- the two half-dot phases of the latch strobe;
- per-line read counts taken by the stub memory;
- the difference between a normal dot 0 and one that follows a dropped dot.

// File: rtl/bgseq_pkg.sv
package bgseq_pkg;

    // Phase of the current dot as seen by the fetch state machine
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_LEAD = 3'd1,
        ST_ADDR = 3'd2,
        ST_READ = 3'd3,
        ST_GAP  = 3'd4
    } phase_e;

    // Kind of background access; the order is the rotation inside a tile slot
    typedef enum logic [1:0] {
        FK_NAME  = 2'd0,
        FK_ATTR  = 2'd1,
        FK_PATLO = 2'd2,
        FK_PATHI = 2'd3
    } fetch_kind_e;

endpackage

// File: rtl/bgseq_window.sv
module bgseq_window
    import bgseq_pkg::*;
#(
    parameter int DOT_W          = 9,
    parameter int LINE_W         = 9,
    parameter int VIS_LINES      = 240,
    parameter int PRE_LINE       = 261,
    parameter int TILE_FETCH_END = 256,
    parameter int PREFETCH_START = 321,
    parameter int DUMMY_START    = 337,
    parameter int LINE_LAST_DOT  = 340
) (
    input  logic [DOT_W-1:0]  dot_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              render_en_i,
    output logic              on_o,
    output logic              lead_o,
    output logic              fetch_dot_o,
    output logic              odd_o,
    output fetch_kind_e       slot_o
);

    localparam logic [DOT_W-1:0]  D_ONE    = DOT_W'(1);
    localparam logic [DOT_W-1:0]  D_TEND   = DOT_W'(TILE_FETCH_END);
    localparam logic [DOT_W-1:0]  D_PSTART = DOT_W'(PREFETCH_START);
    localparam logic [DOT_W-1:0]  D_DSTART = DOT_W'(DUMMY_START);
    localparam logic [DOT_W-1:0]  D_LAST   = DOT_W'(LINE_LAST_DOT);
    localparam logic [LINE_W-1:0] L_VIS    = LINE_W'(VIS_LINES);
    localparam logic [LINE_W-1:0] L_PRE    = LINE_W'(PRE_LINE);

    logic       dummy;
    logic [1:0] slot_bits;

    always_comb begin
        on_o        = render_en_i && ((line_i < L_VIS) || (line_i == L_PRE));
        lead_o      = (dot_i == '0);
        fetch_dot_o = ((dot_i >= D_ONE) && (dot_i <= D_TEND)) ||
                      ((dot_i >= D_PSTART) && (dot_i <= D_LAST));
        odd_o       = dot_i[0];
        dummy       = (dot_i >= D_DSTART) && (dot_i <= D_LAST);
        slot_bits   = 2'((dot_i - D_ONE) >> 1);
        slot_o      = dummy ? FK_NAME : fetch_kind_e'(slot_bits);
    end

endmodule

// File: rtl/bgseq_phase_fsm.sv
module bgseq_phase_fsm
    import bgseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        on_i,
    input  logic        lead_i,
    input  logic        fetch_dot_i,
    input  logic        odd_i,
    input  fetch_kind_e slot_i,
    output logic        fetch_active_o,
    output fetch_kind_e kind_o,
    output logic        ale_o,
    output logic        rd_n_o
);

    phase_e      state_q, state_d;
    fetch_kind_e kind_q, kind_d;
    logic        ale_phase;

    // Next-state selection
    always_comb begin
        state_d = ST_OFF;
        kind_d  = FK_NAME;
        if (on_i) begin
            if (lead_i) begin
                if (state_q == ST_ADDR) begin
                    state_d = ST_READ;          // dropped dot: finish the pending fetch
                    kind_d  = kind_q;
                end else begin
                    state_d = ST_LEAD;
                end
            end else if (fetch_dot_i) begin
                state_d = odd_i ? ST_ADDR : ST_READ;
                kind_d  = slot_i;
            end else begin
                state_d = ST_GAP;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            kind_q  <= FK_NAME;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    // Outputs from state
    always_comb begin
        ale_phase      = 1'b0;
        rd_n_o         = 1'b1;
        fetch_active_o = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_GAP:  ;
            ST_LEAD: ale_phase = 1'b1;
            ST_ADDR: begin
                ale_phase      = 1'b1;
                fetch_active_o = 1'b1;
            end
            ST_READ: begin
                rd_n_o         = 1'b0;
                fetch_active_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign kind_o = kind_q;
    assign ale_o  = ale_phase & clk;   // high only in the first half of the dot

    AST_READ_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> ($past(state_q) == ST_ADDR)); // R12

endmodule

// File: rtl/bgseq_scroll_pulses.sv
module bgseq_scroll_pulses #(
    parameter int DOT_W          = 9,
    parameter int LINE_W         = 9,
    parameter int PRE_LINE       = 261,
    parameter int TILE_FETCH_END = 256,
    parameter int PREFETCH_START = 321,
    parameter int DUMMY_START    = 337,
    parameter int VLOAD_FIRST    = 280,
    parameter int VLOAD_LAST     = 304
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on_i,
    input  logic [DOT_W-1:0]  dot_i,
    input  logic [LINE_W-1:0] line_i,
    output logic              hinc_o,
    output logic              vinc_o,
    output logic              hload_o,
    output logic              vload_o
);

    localparam int              TILE_DOTS = 8;
    localparam logic [DOT_W-1:0] D_FIRST_H = DOT_W'(TILE_DOTS);
    localparam logic [DOT_W-1:0] D_TEND    = DOT_W'(TILE_FETCH_END);
    localparam logic [DOT_W-1:0] D_HLOAD   = DOT_W'(TILE_FETCH_END + 1);
    localparam logic [DOT_W-1:0] D_PSTART  = DOT_W'(PREFETCH_START);
    localparam logic [DOT_W-1:0] D_PEND    = DOT_W'(DUMMY_START - 1);
    localparam logic [DOT_W-1:0] D_VL_LO   = DOT_W'(VLOAD_FIRST);
    localparam logic [DOT_W-1:0] D_VL_HI   = DOT_W'(VLOAD_LAST);
    localparam logic [LINE_W-1:0] L_PRE    = LINE_W'(PRE_LINE);

    logic [DOT_W-1:0] pre_rel;
    logic             hinc_d, vinc_d, hload_d, vload_d;

    always_comb begin
        pre_rel = dot_i - D_PSTART;
        hinc_d  = on_i && (
                    ((dot_i >= D_FIRST_H) && (dot_i <= D_TEND) && (dot_i[2:0] == 3'd0)) ||
                    ((dot_i >= D_PSTART) && (dot_i <= D_PEND) && (pre_rel[2:0] == 3'd7)));
        vinc_d  = on_i && (dot_i == D_TEND);
        hload_d = on_i && (dot_i == D_HLOAD);
        vload_d = on_i && (line_i == L_PRE) && (dot_i >= D_VL_LO) && (dot_i <= D_VL_HI);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hinc_o  <= 1'b0;
            vinc_o  <= 1'b0;
            hload_o <= 1'b0;
            vload_o <= 1'b0;
        end else begin
            hinc_o  <= hinc_d;
            vinc_o  <= vinc_d;
            hload_o <= hload_d;
            vload_o <= vload_d;
        end
    end

endmodule

// File: rtl/bg_fetch_seq.sv
module bg_fetch_seq
    import bgseq_pkg::*;
#(
    parameter int DOT_W          = 9,
    parameter int LINE_W         = 9,
    parameter int VIS_LINES      = 240,
    parameter int PRE_LINE       = 261,
    parameter int TILE_FETCH_END = 256,
    parameter int PREFETCH_START = 321,
    parameter int DUMMY_START    = 337,
    parameter int LINE_LAST_DOT  = 340,
    parameter int VLOAD_FIRST    = 280,
    parameter int VLOAD_LAST     = 304
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DOT_W-1:0]  dot_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              render_en_i,
    output logic              fetch_active_o,
    output logic [1:0]        fetch_kind_o,
    output logic              ale_o,
    output logic              rd_n_o,
    output logic              hinc_o,
    output logic              vinc_o,
    output logic              hload_o,
    output logic              vload_o
);

    logic        on, lead, fetch_dot, odd;
    fetch_kind_e slot, kind;

    bgseq_window #(
        .DOT_W(DOT_W), .LINE_W(LINE_W), .VIS_LINES(VIS_LINES), .PRE_LINE(PRE_LINE),
        .TILE_FETCH_END(TILE_FETCH_END), .PREFETCH_START(PREFETCH_START),
        .DUMMY_START(DUMMY_START), .LINE_LAST_DOT(LINE_LAST_DOT)
    ) u_window (
        .dot_i(dot_i), .line_i(line_i), .render_en_i(render_en_i),
        .on_o(on), .lead_o(lead), .fetch_dot_o(fetch_dot), .odd_o(odd), .slot_o(slot)
    );

    bgseq_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .on_i(on), .lead_i(lead), .fetch_dot_i(fetch_dot),
        .odd_i(odd), .slot_i(slot), .fetch_active_o(fetch_active_o), .kind_o(kind),
        .ale_o(ale_o), .rd_n_o(rd_n_o)
    );

    bgseq_scroll_pulses #(
        .DOT_W(DOT_W), .LINE_W(LINE_W), .PRE_LINE(PRE_LINE),
        .TILE_FETCH_END(TILE_FETCH_END), .PREFETCH_START(PREFETCH_START),
        .DUMMY_START(DUMMY_START), .VLOAD_FIRST(VLOAD_FIRST), .VLOAD_LAST(VLOAD_LAST)
    ) u_pulses (
        .clk(clk), .rst_n(rst_n), .on_i(on), .dot_i(dot_i), .line_i(line_i),
        .hinc_o(hinc_o), .vinc_o(vinc_o), .hload_o(hload_o), .vload_o(vload_o)
    );

    assign fetch_kind_o = kind;

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !render_en_i |=> (rd_n_o && !fetch_active_o && !hinc_o && !vinc_o && !hload_o && !vload_o)); // R11
    AST_VINC_WITH_HINC: assert property (@(posedge clk) disable iff (!rst_n)
        vinc_o |-> hinc_o); // R8
    AST_HLOAD_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        hload_o |-> (!fetch_active_o && rd_n_o)); // R10

endmodule

// File: tb/tb_bg_fetch_seq.sv
`timescale 1ns/1ps
module tb_bg_fetch_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] dot = '0;
    logic [8:0] line = 9'd240;
    logic       rend = 1'b0;
    logic       fetch_active, ale, rd_n, hinc, vinc, hload, vload;
    logic [1:0] kind;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit prev_addr = 0;
    int cnt [4];

    always #2.5 clk = ~clk;

    bg_fetch_seq dut (
        .clk(clk), .rst_n(rst_n), .dot_i(dot), .line_i(line), .render_en_i(rend),
        .fetch_active_o(fetch_active), .fetch_kind_o(kind), .ale_o(ale), .rd_n_o(rd_n),
        .hinc_o(hinc), .vinc_o(vinc), .hload_o(hload), .vload_o(vload)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One dot: inputs are applied just after a falling edge; sampled in both clock halves.
    task automatic step(input int d, input int l, input bit r);
        bit on, e_lead, e_addr, e_read, e_h, e_v, e_hl, e_vl;
        int e_kind;
        string tf, ts;
        dot = 9'(d); line = 9'(l); rend = r;
        on = r && (l < 240 || l == 261);
        e_lead = 0; e_addr = 0; e_read = 0; e_kind = 0;
        tf = "R3";
        if (!on) tf = "R11";
        else if (d == 0) begin
            if (prev_addr) begin e_read = 1; tf = "R12"; end
            else begin e_lead = 1; tf = "R2"; end
        end else if ((d >= 1 && d <= 256) || (d >= 321 && d <= 340)) begin
            if (d % 2 == 1) e_addr = 1; else e_read = 1;
            if (d >= 337) begin e_kind = 0; tf = "R6"; end
            else e_kind = ((d - 1) / 2) % 4;
        end else tf = "R10";
        prev_addr = e_addr;
        ts = e_read ? "R5" : (e_addr ? "R4" : tf);
        e_h  = on && ((d >= 8 && d <= 256 && d % 8 == 0) || d == 328 || d == 336);
        e_v  = on && d == 256;
        e_hl = on && d == 257;
        e_vl = on && l == 261 && d >= 280 && d <= 304;
        @(posedge clk); #1;
        check(tf, "fetch_active", fetch_active, int'(e_addr | e_read));
        if (e_addr | e_read) check(tf, "fetch_kind", kind, e_kind);
        check(ts, "ale high half", ale, int'(e_lead | e_addr));
        check(ts, "rd_n", rd_n, int'(!e_read));
        check(on ? "R7" : "R11", "hinc", hinc, int'(e_h));
        check(on ? "R8" : "R11", "vinc", vinc, int'(e_v));
        check(on ? "R8" : "R11", "hload", hload, int'(e_hl));
        check(on ? "R9" : "R11", "vload", vload, int'(e_vl));
        if (!rd_n) cnt[kind]++;          // stub memory records each read
        @(negedge clk); #0.5;
        check("R4", "ale low half", ale, 0);
        check(ts, "rd_n low half", rd_n, int'(!e_read));
    endtask

    task automatic run_line(input int l, input bit r, input int last_dot,
                            input int e_nt, input int e_other, input string tag);
        for (int k = 0; k < 4; k++) cnt[k] = 0;
        for (int d = 0; d <= last_dot; d++) step(d, l, r);
        check(tag, "nametable reads", cnt[0], e_nt);
        check(tag, "attribute reads", cnt[1], e_other);
        check(tag, "pattern low reads", cnt[2], e_other);
        check(tag, "pattern high reads", cnt[3], e_other);
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1", "fetch_active", fetch_active, 0);
        check("R1", "rd_n", rd_n, 1);
        check("R1", "ale", ale, 0);
        check("R1", "kind", kind, 0);
        check("R1", "pulses", {hinc, vinc, hload, vload}, 0);
        @(negedge clk); #0.5;
        rst_n = 1'b1;
        prev_addr = 0;
    endtask

    task automatic test_visible_line();
        run_line(5, 1, 340, 36, 34, "R3");
        run_line(239, 1, 340, 36, 34, "R6");
    endtask

    task automatic test_quiet_lines();
        run_line(240, 1, 340, 0, 0, "R11");
        run_line(250, 1, 340, 0, 0, "R11");
        run_line(7, 0, 340, 0, 0, "R11");
    endtask

    task automatic test_even_frame();
        run_line(261, 1, 340, 36, 34, "R9");
        // line 0 after a full pre-render line: dot 0 is a plain latch pulse (R2)
        run_line(0, 1, 340, 36, 34, "R2");
    endtask

    task automatic test_odd_frame();
        run_line(261, 1, 339, 35, 34, "R6");
        // dot 0 completes the second throwaway nametable read (R12)
        run_line(0, 1, 340, 37, 34, "R12");
    endtask

    initial begin
        fork
            begin
                test_reset();
                test_visible_line();
                test_quiet_lines();
                test_even_frame();
                test_odd_frame();
                test_visible_line();
            end
            begin
                #(200000 * 5);
                if (!done) begin
                    checks++;
                    fails++;
                    $display("FAIL watchdog: got timeout expected completion");
                end
            end
        join_any
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule